// File: doc/BRIEF.md
# DC-Balance Lane Encoder

This block prepares one lane of a wide parallel-to-serial link. On each accepted clock cycle it takes a 6-bit data word and produces a 7-bit lane word. The lane word holds the data, either as-is or bit-inverted, plus a flag bit that tells the far end which form was sent. A signed running-disparity register tracks the lane's accumulated imbalance between ones and zeros. For every word it decides whether inversion will pull that imbalance back toward zero, so the lane's DC content stays bounded. Eight such lanes side by side carry 48 data bits per clock.

Each cycle the encoder takes one of four actions. `ACT_HOLD` applies when enable or valid is low: outputs and disparity keep their values. `ACT_RAW` applies in bypass: the data passes through with the flag at 0 and the disparity frozen. `ACT_PLAIN` sends the data unchanged with the flag at 0. `ACT_INVERT` sends the complement with the flag at 1. The step to `ACT_PLAIN` or `ACT_INVERT` follows the polarity rule in R3 to R5, and only those two actions move the disparity. A synchronous reset loads the disparity from a reset-value input, clamped into the legal window.

Top module: `dcb_lane_enc`

## Requirements
- R1: While reset is low, a rising clock edge sets the lane word to 0 and loads the running disparity from the reset-value input when that value lies in [-6, +7].
- R2: Word disparity is the count of 1 bits minus the count of 0 bits. The lane word carries the flag in bit 6 and the payload in bits 5:0. With the flag at 0 the payload equals the input word, and with the flag at 1 it equals the bitwise complement, so re-inverting on the flag recovers the data.
- R3: With the running disparity above zero, the word is inverted exactly when its word disparity is above zero.
- R4: With the running disparity below zero, the word is inverted exactly when its word disparity is zero or below.
- R5: With the running disparity exactly zero, the word is always inverted.
- R6: After an accepted non-bypass word, the running disparity changes by (word disparity − 1) if sent plain, or by (1 − word disparity) if inverted. The new lane word and disparity appear after the same rising edge that captured the input.
- R7: The running disparity saturates at +7 and −6 and never leaves that window; the extremes +7 and −6 are reachable.
- R8: With bypass high on an accepted cycle, the lane word becomes {0, data} and the running disparity is unchanged.
- R9: On a cycle where enable or valid is low, the lane word and running disparity are unchanged, whatever the data input holds.
- R10: A reset value above +7 loads +7, and one below −6 loads −6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable for the whole lane |
| bypass | input | 1 | Pass data through without balancing |
| in_vld | input | 1 | Input word present this cycle |
| in_data | input | 6 | Data word for the lane |
| rd_init | input | 5 | Signed reset value for the running disparity |
| lane_word | output | 7 | Flag (bit 6) and payload (bits 5:0) |
| run_disp | output | 5 | Signed running disparity |

## Verification
Hand-picked words of all ones and all zeros are sent from disparity zero, negative and positive. They separate the three polarity branches and drive the disparity exactly onto +7 and −6. A balanced word (three ones) tells the "zero or below" arm of R4 apart from the "above zero" arm of R3. Seeded random words mixed with bypass and idle cycles show that the disparity bookkeeping stays in step over long runs and that a frozen disparity resumes correctly. Out-of-range reset values and enable-low or valid-low cycles with live data show that clamping and holding leave no trace on the outputs.

// File: rtl/dcb_pkg.sv
`timescale 1ns/1ps
package dcb_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_RAW    = 2'd1,
        ACT_PLAIN  = 2'd2,
        ACT_INVERT = 2'd3
    } lane_act_e;
endpackage

// File: rtl/dcb_word_disp.sv
`timescale 1ns/1ps
module dcb_word_disp #(
    parameter int DATA_W = 6,
    parameter int DW     = 5
) (
    input  logic [DATA_W-1:0]   word,
    output logic signed [DW-1:0] disp
);
    int ones;
    always_comb begin
        ones = 0;
        for (int i = 0; i < DATA_W; i++) begin
            ones = ones + int'(word[i]);
        end
        disp = DW'(2 * ones - DATA_W);
    end
endmodule

// File: rtl/dcb_polarity.sv
`timescale 1ns/1ps
module dcb_polarity #(
    parameter int RD_W = 5,
    parameter int DW   = 5
) (
    input  logic signed [RD_W-1:0] rd,
    input  logic signed [DW-1:0]   disp,
    output logic                   inv
);
    logic rd_zero, rd_pos, d_pos;
    always_comb begin
        rd_zero = (rd == 0);
        rd_pos  = (rd > 0);
        d_pos   = (disp > 0);
        inv     = rd_zero | (rd_pos & d_pos) | (!rd_pos & !rd_zero & !d_pos);
    end
endmodule

// File: rtl/dcb_rd_step.sv
`timescale 1ns/1ps
module dcb_rd_step #(
    parameter int RD_W   = 5,
    parameter int DW     = 5,
    parameter int RD_MAX = 7,
    parameter int RD_MIN = -6
) (
    input  logic signed [RD_W-1:0] rd,
    input  logic signed [DW-1:0]   disp,
    input  logic                   inv,
    output logic signed [RD_W-1:0] rd_nxt
);
    localparam int SW = ((RD_W > DW) ? RD_W : DW) + 2;
    localparam logic signed [SW-1:0] ONE = SW'(1);
    localparam logic signed [SW-1:0] HI  = SW'(RD_MAX);
    localparam logic signed [SW-1:0] LO  = SW'(RD_MIN);

    logic signed [SW-1:0] rd_x, d_x, sum;
    always_comb begin
        rd_x = SW'(rd);
        d_x  = SW'(disp);
        sum  = inv ? (rd_x + ONE - d_x) : (rd_x + d_x - ONE);
        if (sum > HI)      rd_nxt = RD_W'(HI);
        else if (sum < LO) rd_nxt = RD_W'(LO);
        else               rd_nxt = RD_W'(sum);
    end
endmodule

// File: rtl/dcb_lane_enc.sv
`timescale 1ns/1ps
module dcb_lane_enc
    import dcb_pkg::*;
#(
    parameter int DATA_W = 6,
    parameter int RD_W   = 5,
    parameter int RD_MAX = 7,
    parameter int RD_MIN = -6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    bypass,
    input  logic                    in_vld,
    input  logic [DATA_W-1:0]       in_data,
    input  logic signed [RD_W-1:0]  rd_init,
    output logic [DATA_W:0]         lane_word,
    output logic signed [RD_W-1:0]  run_disp
);
    localparam int DW = $clog2(DATA_W + 1) + 2;
    localparam logic signed [RD_W-1:0] RD_HI = RD_W'(RD_MAX);
    localparam logic signed [RD_W-1:0] RD_LO = RD_W'(RD_MIN);

    logic signed [RD_W-1:0] rd_q, rd_nxt, rd_load;
    logic signed [DW-1:0]   w_disp;
    logic                   inv;
    logic [DATA_W:0]        lane_q;
    lane_act_e              act;

    dcb_word_disp #(.DATA_W(DATA_W), .DW(DW)) u_disp (
        .word (in_data),
        .disp (w_disp)
    );

    dcb_polarity #(.RD_W(RD_W), .DW(DW)) u_pol (
        .rd   (rd_q),
        .disp (w_disp),
        .inv  (inv)
    );

    dcb_rd_step #(.RD_W(RD_W), .DW(DW), .RD_MAX(RD_MAX), .RD_MIN(RD_MIN)) u_step (
        .rd     (rd_q),
        .disp   (w_disp),
        .inv    (inv),
        .rd_nxt (rd_nxt)
    );

    // clamp the reset value into the legal window
    always_comb begin
        if (rd_init > RD_HI)      rd_load = RD_HI;
        else if (rd_init < RD_LO) rd_load = RD_LO;
        else                      rd_load = rd_init;
    end

    // per-cycle action selection
    always_comb begin
        if (!(en && in_vld)) act = ACT_HOLD;
        else if (bypass)     act = ACT_RAW;
        else if (inv)        act = ACT_INVERT;
        else                 act = ACT_PLAIN;
    end

    // disparity state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= rd_load;
        end else begin
            unique case (act)
                ACT_HOLD:   rd_q <= rd_q;
                ACT_RAW:    rd_q <= rd_q;
                ACT_PLAIN:  rd_q <= rd_nxt;
                ACT_INVERT: rd_q <= rd_nxt;
            endcase
        end
    end

    // lane word output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            unique case (act)
                ACT_HOLD:   lane_q <= lane_q;
                ACT_RAW:    lane_q <= {1'b0, in_data};
                ACT_PLAIN:  lane_q <= {1'b0, in_data};
                ACT_INVERT: lane_q <= {1'b1, ~in_data};
            endcase
        end
    end

    assign lane_word = lane_q;
    assign run_disp  = rd_q;
endmodule

// File: rtl/dcb_lane_enc_chk.sv
`timescale 1ns/1ps
module dcb_lane_enc_chk #(
    parameter int DATA_W = 6,
    parameter int RD_W   = 5,
    parameter int RD_MAX = 7,
    parameter int RD_MIN = -6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en,
    input logic                   bypass,
    input logic                   in_vld,
    input logic [DATA_W-1:0]      in_data,
    input logic [DATA_W:0]        lane_word,
    input logic signed [RD_W-1:0] run_disp
);
    logic take, word_pos;
    assign take     = en && in_vld && !bypass;
    assign word_pos = (2 * $countones(in_data)) > DATA_W;

    // R7
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_disp <= RD_MAX) && (run_disp >= RD_MIN));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && in_vld) |=> $stable(lane_word) && $stable(run_disp));

    // R8
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_vld && bypass) |=>
            (lane_word == {1'b0, $past(in_data)}) && $stable(run_disp));

    // R5
    zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && run_disp == 0) |=> lane_word[DATA_W]);

    // R3
    pos_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && run_disp > 0) |=> (lane_word[DATA_W] == $past(word_pos)));

    // R4
    neg_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && run_disp < 0) |=> (lane_word[DATA_W] == !$past(word_pos)));

    // R2
    payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (lane_word[DATA_W-1:0] ==
                  (lane_word[DATA_W] ? ~$past(in_data) : $past(in_data))));
endmodule

bind dcb_lane_enc dcb_lane_enc_chk #(
    .DATA_W(DATA_W), .RD_W(RD_W), .RD_MAX(RD_MAX), .RD_MIN(RD_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .bypass    (bypass),
    .in_vld    (in_vld),
    .in_data   (in_data),
    .lane_word (lane_word),
    .run_disp  (run_disp)
);

// File: tb/sim_dcb_lane_enc.sv
`timescale 1ns/1ps
module sim_dcb_lane_enc;
    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic bypass = 1'b0;
    logic in_vld = 1'b0;
    logic [W-1:0] in_data = '0;
    logic signed [4:0] rd_init = '0;
    logic [W:0] lane_word;
    logic signed [4:0] run_disp;

    int checks = 0;
    int fails = 0;
    int model_rd = 0;
    logic pend = 1'b0;

    typedef struct {
        logic [W:0]   w;
        int           rd;
        logic [W-1:0] d;
        int           tw;
        int           tr;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    dcb_lane_enc u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .in_vld(in_vld),
        .in_data(in_data), .rd_init(rd_init), .lane_word(lane_word), .run_disp(run_disp)
    );

    function automatic string tag(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   default: return "R10";
        endcase
    endfunction

    function automatic int clampv(input int v);
        if (v > 7)  return 7;
        if (v < -6) return -6;
        return v;
    endfunction

    task automatic check(input bit ok, input int t, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag(t), act, exp);
        end
    endtask

    // driver: present one word, push the expected result
    task automatic send(input logic [W-1:0] d, input logic byp);
        exp_t e;
        int dd, nr;
        logic inv;
        dd = 2 * $countones(d) - W;
        e.d = d;
        if (byp) begin
            e.w = {1'b0, d}; e.rd = model_rd; e.tw = 8; e.tr = 8;
        end else begin
            inv = (model_rd == 0) || (model_rd > 0 && dd > 0) || (model_rd < 0 && dd <= 0);
            nr  = clampv(inv ? model_rd + 1 - dd : model_rd + dd - 1);
            e.w = {inv, inv ? ~d : d};
            e.tw = (model_rd == 0) ? 5 : ((model_rd > 0) ? 3 : 4);
            e.tr = (nr == 7 || nr == -6) ? 7 : 6;
            model_rd = nr;
            e.rd = nr;
        end
        q.push_back(e);
        en = 1'b1; in_vld = 1'b1; bypass = byp; in_data = d;
        @(negedge clk);
    endtask

    task automatic idle();
        en = 1'b1; in_vld = 1'b0; bypass = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(input int init);
        rst_n = 1'b0; en = 1'b0; in_vld = 1'b0; bypass = 1'b0;
        rd_init = 5'(init);
        @(negedge clk);
        @(negedge clk);
        model_rd = clampv(init);
    endtask

    // monitor: compare each produced word against the queue
    always @(posedge clk) pend <= rst_n && en && in_vld;

    always @(negedge clk) begin
        if (pend) begin
            if (q.size() == 0) begin
                check(1'b0, 6, 0, 1);
            end else begin
                exp_t e;
                logic [W-1:0] rec;
                e = q.pop_front();
                check(lane_word == e.w, e.tw, int'(lane_word), int'(e.w));
                check(int'(run_disp) == e.rd, e.tr, int'(run_disp), e.rd);
                rec = lane_word[W] ? ~lane_word[W-1:0] : lane_word[W-1:0];
                check(rec == e.d, 2, int'(rec), int'(e.d));
                check(int'(run_disp) <= 7 && int'(run_disp) >= -6, 7, int'(run_disp), e.rd);
            end
        end
    end

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [W:0] lw;
        int r;
        @(negedge clk);
        // R10: out-of-range reset values clamp
        do_reset(12);
        check(int'(run_disp) == 7, 10, int'(run_disp), 7);
        do_reset(-10);
        check(int'(run_disp) == -6, 10, int'(run_disp), -6);
        // R1: in-range reset values load as given
        do_reset(-6);
        check(int'(run_disp) == -6, 1, int'(run_disp), -6);
        do_reset(0);
        check(lane_word == '0, 1, int'(lane_word), 0);
        check(int'(run_disp) == 0, 1, int'(run_disp), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed branches: R5 from zero, R4 negative, R3 positive
        send(6'b111111, 1'b0);   // rd 0 -> invert, -5
        send(6'b000000, 1'b0);   // rd -5 -> invert, +2
        send(6'b111100, 1'b0);   // rd 2, d=2 -> invert, +1
        send(6'b000111, 1'b0);   // rd 1, d=0 -> plain, 0
        send(6'b000000, 1'b0);   // rd 0 -> invert, +7 (R7 upper bound)
        send(6'b000111, 1'b0);   // rd 7, d=0 -> plain, 6
        send(6'b110000, 1'b0);   // rd 6, d=-2 -> plain, 3
        send(6'b111111, 1'b0);   // rd 3, d=6 -> invert, -2
        send(6'b101010, 1'b0);   // rd -2, d=0 -> invert, -1 (R4 balanced)
        send(6'b111100, 1'b0);   // rd -1, d=2 -> plain, 0
        send(6'b111111, 1'b0);   // rd 0 -> invert, -5
        send(6'b111100, 1'b0);   // rd -5, d=2 -> plain, -4
        send(6'b000001, 1'b0);   // rd -4, d=-4 -> invert, +1
        send(6'b000000, 1'b0);   // rd 1, d=-6 -> plain, -6 (R7 lower bound)
        // R8: bypass keeps disparity
        send(6'b110011, 1'b1);
        send(6'b000000, 1'b1);
        idle();
        idle();

        // R9: enable low, then valid low, with live data
        lw = lane_word; r = int'(run_disp);
        en = 1'b0; in_vld = 1'b1; in_data = 6'h2A;
        @(negedge clk);
        check(lane_word == lw, 9, int'(lane_word), int'(lw));
        check(int'(run_disp) == r, 9, int'(run_disp), r);
        en = 1'b1; in_vld = 1'b0; in_data = 6'h15;
        @(negedge clk);
        check(lane_word == lw, 9, int'(lane_word), int'(lw));
        check(int'(run_disp) == r, 9, int'(run_disp), r);

        // random traffic with bypass and idle gaps (R6 bookkeeping)
        void'($urandom(32'h5A17));
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 7) == 0) idle();
            else send(W'($urandom), (($urandom % 8) == 0));
        end
        idle();
        idle();
        check(q.size() == 0, 6, q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule